// File: doc/BRIEF.md
# Multiphase Digital PWM Generator

This block turns a duty command into up to six gate-control waveforms that share one switching period. A prescaled time base counts one switching cycle of 2^DW ticks. Each output either starts its pulse at the beginning of the cycle (pulse-width timing) or at a programmable tick offset inside the cycle, wrapping round the cycle boundary (phase-shift timing). The duty command is taken from the loop compensation filter or from a processor-written value. It is captured once per cycle. A fractional dither field lengthens the pulse by one tick in a pseudo-random share of cycles, so the time-averaged resolution goes beyond DW bits.

Protection and control sit in front of the output registers. These are: an enable input with selectable polarity, a per-output level used while disabled, a separate per-output level used during over-current shutdown, a per-output force for software bypass, and a terminate request from the peak-current comparator that blanks the active pulses for the rest of the cycle. A synchronisation input restarts the cycle on a qualified rising edge, so several generators can share one frame.

Top module: `dpwm_multiphase`

## Requirements
- R1: With speed code 00, one cycle lasts 2^DW clocks. A pulse-width output (mode bit 0) is high for exactly `duty` ticks per cycle, starting at the cycle start, whatever its offset input holds.
- R2: A phase-shift output (mode bit 1) is high in the ticks whose position p within the cycle satisfies ((p - offset) mod 2^DW) < duty. The pulse therefore wraps past the cycle end.
- R3: The speed code sets the tick length: 00 is one clock, 01 is four clocks, and 10 or 11 is eight clocks. Pulse width and period scale by that factor.
- R4: A duty change takes effect only at the next cycle start. The pulse in progress keeps its old width.
- R5: When duty_src_i is 1 the CPU duty value is used. When it is 0 the filter duty value is used.
- R6: A rising edge on sync_i restarts the cycle only if sync_i was sampled low on at least 3 ticks just before it. The restarted pulse appears two clocks after the accepting edge. An edge with only 2 low ticks before it is ignored.
- R7: The block is enabled when en_i equals en_pol_i (1 = active high). While disabled, each output not in bypass drives its stop_dis_i bit one clock later.
- R8: While ocp_i is high, every output drives its stop_ocp_i bit one clock later. This overrides bypass and disable.
- R9: Outputs with a set byp_en_i bit drive byp_val_i one clock later, taking priority over disable. The other outputs keep modulating.
- R10: A terminate request drives all modulating outputs low from the next clock until the cycle ends. Modulation resumes in the next cycle.
- R11: With dither fraction 0, every pulse is exactly `duty` ticks long. With a non-zero fraction f, pulses are `duty` or `duty`+1 ticks long, and the share of lengthened cycles follows f/2^FW.
- R12: During reset all gate outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast time-base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| spd_i | input | 2 | Speed code: 00 = /1, 01 = /4, 1x = /8 |
| sync_i | input | 1 | Frame synchronisation input |
| en_i | input | 1 | Supply enable |
| en_pol_i | input | 1 | Enable polarity, 1 = active high |
| duty_src_i | input | 1 | Duty source select, 1 = CPU value |
| filt_duty_i | input | DW | Duty from the compensation filter |
| cpu_duty_i | input | DW | Duty written by the CPU |
| dith_frac_i | input | FW | Dither fraction in 1/2^FW tick |
| ph_mode_i | input | NPH | Per-output timing mode, 1 = phase shift |
| ph_ofs_i | input | NPH*DW | Per-output start offset in ticks, output k at bits k*DW |
| term_i | input | 1 | Terminate-pulse request from the current limiter |
| ocp_i | input | 1 | Over-current shutdown active |
| stop_dis_i | input | NPH | Output levels while disabled |
| stop_ocp_i | input | NPH | Output levels during over-current shutdown |
| byp_en_i | input | NPH | Per-output software bypass select |
| byp_val_i | input | NPH | Per-output bypass level |
| gate_o | output | NPH | Gate-control outputs |

## Verification
Stop levels, bypass forces and terminate blanking reach gate_o one clock after the inputs are sampled. The bench therefore drives at a falling edge and checks at the very next falling edge. Duty, source and dither changes land only at a cycle boundary, so the bench waits at least two full cycles before it measures, or it counts pulse lengths from rise to fall. For timing, each waveform check is anchored on an observed rising edge of output 0. At that sample the counter position equals the sample index plus one. Phase-shift levels, the sync restart (low at index 3+L, high at 4+L for a low run of L ticks) and the terminate window (low from index 4 to 15, high again at 16) are all derived from that anchor.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;

  // Prescaler terminal count for a speed code: a tick every 1, 4 or 8 clocks
  function automatic logic [2:0] pre_limit(input logic [1:0] spd);
    case (spd)
      2'b00:   return 3'd0;
      2'b01:   return 3'd3;
      default: return 3'd7;
    endcase
  endfunction

  // Output level selection, highest priority first:
  // over-current stop, software force, disable stop, modulation
  function automatic logic gate_pick(input logic ocp, input logic ocp_lvl,
                                     input logic byp, input logic byp_lvl,
                                     input logic en, input logic dis_lvl,
                                     input logic pwm);
    if (ocp) return ocp_lvl;
    if (byp) return byp_lvl;
    if (!en) return dis_lvl;
    return pwm;
  endfunction

endpackage

// File: rtl/dpwm_timebase.sv
module dpwm_timebase #(
  parameter int DW       = 9,
  parameter int SYNC_LOW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    spd_i,
  input  logic          sync_i,
  output logic [DW-1:0] cnt_o,
  output logic          fs_o,
  output logic          sync_acc_o
);
  localparam int SLW = $clog2(SYNC_LOW + 1);
  localparam logic [DW-1:0] CNT_LAST = '1;

  logic [2:0]     pre_q;
  logic [SLW-1:0] low_q;
  logic [DW-1:0]  cnt_q;
  logic           tick;

  assign tick       = (pre_q >= dpwm_pkg::pre_limit(spd_i));
  // edge qualified by a saturated count of low ticks just before it
  assign sync_acc_o = sync_i && (low_q == SLW'(SYNC_LOW));
  assign fs_o       = sync_acc_o || (tick && (cnt_q == CNT_LAST));
  assign cnt_o      = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q <= '0;
      low_q <= '0;
      cnt_q <= '0;
    end else begin
      if (sync_i)
        low_q <= '0;
      else if (tick && (low_q != SLW'(SYNC_LOW)))
        low_q <= low_q + 1'b1;

      if (sync_acc_o) begin
        pre_q <= '0;
        cnt_q <= '0;
      end else if (tick) begin
        pre_q <= '0;
        cnt_q <= cnt_q + 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/dpwm_dither.sv
module dpwm_dither #(
  parameter int              FW   = 6,
  parameter int              LFW  = 16,
  parameter logic [LFW-1:0]  POLY = 'hB400,
  parameter logic [LFW-1:0]  SEED = 'hACE1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv_i,
  input  logic [FW-1:0] frac_i,
  output logic          bump_o
);
  logic [LFW-1:0] lfsr_q;
  logic           bump_q;

  function automatic logic [LFW-1:0] lfsr_step(input logic [LFW-1:0] v);
    return v[0] ? ((v >> 1) ^ POLY) : (v >> 1);
  endfunction

  // one extra tick whenever the random field falls below the fraction
  function automatic logic want_bump(input logic [FW-1:0] rnd, input logic [FW-1:0] frac);
    return rnd < frac;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lfsr_q <= SEED;
      bump_q <= 1'b0;
    end else if (adv_i) begin
      lfsr_q <= lfsr_step(lfsr_q);
      bump_q <= want_bump(lfsr_q[FW-1:0], frac_i);
    end
  end

  assign bump_o = bump_q;

endmodule

// File: rtl/dpwm_phase.sv
module dpwm_phase #(
  parameter int DW = 9
) (
  input  logic [DW-1:0] cnt_i,
  input  logic [DW-1:0] start_i,
  input  logic          mode_i,
  input  logic [DW:0]   width_i,
  output logic          on_o
);
  logic [DW-1:0] start_eff;
  logic [DW-1:0] pos;

  // position relative to the pulse start, wrapping modulo the cycle
  function automatic logic in_window(input logic [DW-1:0] p, input logic [DW:0] w);
    return {1'b0, p} < w;
  endfunction

  assign start_eff = mode_i ? start_i : '0;
  assign pos       = cnt_i - start_eff;
  assign on_o      = in_window(pos, width_i);

endmodule

// File: rtl/dpwm_gate_ctl.sv
module dpwm_gate_ctl #(
  parameter int NPH = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           fs_i,
  input  logic           term_i,
  input  logic           ocp_i,
  input  logic           enabled_i,
  input  logic [NPH-1:0] raw_i,
  input  logic [NPH-1:0] stop_dis_i,
  input  logic [NPH-1:0] stop_ocp_i,
  input  logic [NPH-1:0] byp_en_i,
  input  logic [NPH-1:0] byp_val_i,
  output logic [NPH-1:0] gate_o
);
  logic           term_q;
  logic           cut;
  logic [NPH-1:0] pwm_v;
  logic [NPH-1:0] gate_d;
  logic [NPH-1:0] gate_q;

  // blanking holds for the rest of the cycle once requested
  assign cut = term_i || term_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      term_q <= 1'b0;
    else if (fs_i)
      term_q <= 1'b0;
    else if (term_i)
      term_q <= 1'b1;
  end

  for (genvar k = 0; k < NPH; k++) begin : g_sel
    assign pwm_v[k]  = raw_i[k] && !cut;
    assign gate_d[k] = dpwm_pkg::gate_pick(ocp_i, stop_ocp_i[k], byp_en_i[k], byp_val_i[k],
                                           enabled_i, stop_dis_i[k], pwm_v[k]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) gate_q <= '0;
    else        gate_q <= gate_d;
  end

  assign gate_o = gate_q;

endmodule

// File: rtl/dpwm_multiphase.sv
module dpwm_multiphase #(
  parameter int NPH = 6,
  parameter int DW  = 9,
  parameter int FW  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        spd_i,
  input  logic              sync_i,
  input  logic              en_i,
  input  logic              en_pol_i,
  input  logic              duty_src_i,
  input  logic [DW-1:0]     filt_duty_i,
  input  logic [DW-1:0]     cpu_duty_i,
  input  logic [FW-1:0]     dith_frac_i,
  input  logic [NPH-1:0]    ph_mode_i,
  input  logic [NPH*DW-1:0] ph_ofs_i,
  input  logic              term_i,
  input  logic              ocp_i,
  input  logic [NPH-1:0]    stop_dis_i,
  input  logic [NPH-1:0]    stop_ocp_i,
  input  logic [NPH-1:0]    byp_en_i,
  input  logic [NPH-1:0]    byp_val_i,
  output logic [NPH-1:0]    gate_o
);
  // named internal events, observed by the bound checker
  logic [DW-1:0]  cnt_q;
  logic           fs_evt;
  logic           sync_acc;
  logic [DW-1:0]  duty_q;
  logic           bump;
  logic [DW:0]    width_eff;
  logic           enabled;
  logic [NPH-1:0] raw_on;

  dpwm_timebase #(.DW(DW), .SYNC_LOW(3)) u_tb (
    .clk        (clk),
    .rst_n      (rst_n),
    .spd_i      (spd_i),
    .sync_i     (sync_i),
    .cnt_o      (cnt_q),
    .fs_o       (fs_evt),
    .sync_acc_o (sync_acc)
  );

  dpwm_dither #(.FW(FW)) u_dith (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv_i  (fs_evt),
    .frac_i (dith_frac_i),
    .bump_o (bump)
  );

  // duty captured once per cycle so no runt pulse can appear
  always_ff @(posedge clk) begin
    if (!rst_n)
      duty_q <= '0;
    else if (fs_evt)
      duty_q <= duty_src_i ? cpu_duty_i : filt_duty_i;
  end

  assign width_eff = {1'b0, duty_q} + (DW+1)'(bump);
  assign enabled   = (en_i == en_pol_i);

  for (genvar k = 0; k < NPH; k++) begin : g_ph
    dpwm_phase #(.DW(DW)) u_ph (
      .cnt_i   (cnt_q),
      .start_i (ph_ofs_i[k*DW +: DW]),
      .mode_i  (ph_mode_i[k]),
      .width_i (width_eff),
      .on_o    (raw_on[k])
    );
  end

  dpwm_gate_ctl #(.NPH(NPH)) u_gc (
    .clk        (clk),
    .rst_n      (rst_n),
    .fs_i       (fs_evt),
    .term_i     (term_i),
    .ocp_i      (ocp_i),
    .enabled_i  (enabled),
    .raw_i      (raw_on),
    .stop_dis_i (stop_dis_i),
    .stop_ocp_i (stop_ocp_i),
    .byp_en_i   (byp_en_i),
    .byp_val_i  (byp_val_i),
    .gate_o     (gate_o)
  );

endmodule

// File: rtl/dpwm_multiphase_chk.sv
module dpwm_multiphase_chk #(
  parameter int NPH = 6,
  parameter int DW  = 9
) (
  input logic           clk,
  input logic           rst_n,
  input logic           en_i,
  input logic           en_pol_i,
  input logic           term_i,
  input logic           ocp_i,
  input logic [NPH-1:0] stop_dis_i,
  input logic [NPH-1:0] stop_ocp_i,
  input logic [NPH-1:0] byp_en_i,
  input logic [NPH-1:0] byp_val_i,
  input logic [NPH-1:0] gate_o,
  input logic           fs_evt,
  input logic           sync_acc,
  input logic [DW-1:0]  cnt_q,
  input logic [DW-1:0]  duty_q
);

  // R1
  frame_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fs_evt |=> (cnt_q == '0));

  // R4
  duty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fs_evt |=> $stable(duty_q));

  // R6
  sync_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_acc |=> (cnt_q == '0));

  // R7
  disable_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ocp_i && (en_i != en_pol_i)) |=>
      ((gate_o & ~$past(byp_en_i)) == $past(stop_dis_i & ~byp_en_i)));

  // R8
  ocp_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ocp_i |=> (gate_o == $past(stop_ocp_i)));

  // R9
  bypass_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ocp_i |=> ((gate_o & $past(byp_en_i)) == $past(byp_val_i & byp_en_i)));

  // R10
  term_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (term_i && !ocp_i && (en_i == en_pol_i)) |=> ((gate_o & ~$past(byp_en_i)) == '0));

endmodule

bind dpwm_multiphase dpwm_multiphase_chk #(.NPH(NPH), .DW(DW)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .en_i       (en_i),
  .en_pol_i   (en_pol_i),
  .term_i     (term_i),
  .ocp_i      (ocp_i),
  .stop_dis_i (stop_dis_i),
  .stop_ocp_i (stop_ocp_i),
  .byp_en_i   (byp_en_i),
  .byp_val_i  (byp_val_i),
  .gate_o     (gate_o),
  .fs_evt     (fs_evt),
  .sync_acc   (sync_acc),
  .cnt_q      (cnt_q),
  .duty_q     (duty_q)
);

// File: tb/dpwm_multiphase_tb_top.sv
module dpwm_multiphase_tb_top;
  localparam int NPH = 6;
  localparam int DW  = 4;
  localparam int FW  = 6;
  localparam int P   = 16;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [1:0]        spd_i;
  logic              sync_i;
  logic              en_i;
  logic              en_pol_i;
  logic              duty_src_i;
  logic [DW-1:0]     filt_duty_i;
  logic [DW-1:0]     cpu_duty_i;
  logic [FW-1:0]     dith_frac_i;
  logic [NPH-1:0]    ph_mode_i;
  logic [NPH*DW-1:0] ph_ofs_i;
  logic              term_i;
  logic              ocp_i;
  logic [NPH-1:0]    stop_dis_i;
  logic [NPH-1:0]    stop_ocp_i;
  logic [NPH-1:0]    byp_en_i;
  logic [NPH-1:0]    byp_val_i;
  logic [NPH-1:0]    gate_o;

  int checks = 0;
  int fails  = 0;
  int cnt_arr [NPH];

  always #5 clk = ~clk;

  dpwm_multiphase #(.NPH(NPH), .DW(DW), .FW(FW)) dut_i (
    .clk(clk), .rst_n(rst_n), .spd_i(spd_i), .sync_i(sync_i), .en_i(en_i),
    .en_pol_i(en_pol_i), .duty_src_i(duty_src_i), .filt_duty_i(filt_duty_i),
    .cpu_duty_i(cpu_duty_i), .dith_frac_i(dith_frac_i), .ph_mode_i(ph_mode_i),
    .ph_ofs_i(ph_ofs_i), .term_i(term_i), .ocp_i(ocp_i), .stop_dis_i(stop_dis_i),
    .stop_ocp_i(stop_ocp_i), .byp_en_i(byp_en_i), .byp_val_i(byp_val_i), .gate_o(gate_o)
  );

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic check_eq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic check_rng(input string tag, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d..%0d", tag, act, lo, hi);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // returns at the sample where output k is first seen high after being low
  task automatic wait_rise(input int k);
    logic prev;
    bit   seen;
    int   guard;
    seen = 0;
    guard = 0;
    @(negedge clk);
    prev = gate_o[k];
    while (!seen && guard < 4000) begin
      @(negedge clk);
      seen = gate_o[k] && !prev;
      prev = gate_o[k];
      guard++;
    end
    if (!seen) check_eq("rise seen", 0, 1);
  endtask

  task automatic run_len(input int k, output int h);
    bit hi;
    h = 1;
    hi = 1;
    while (hi && h < 2000) begin
      @(negedge clk);
      if (gate_o[k]) h++;
      else hi = 0;
    end
  endtask

  task automatic low_len(input int k, output int l);
    bit lo;
    l = 1;
    lo = 1;
    while (lo && l < 4000) begin
      @(negedge clk);
      if (!gate_o[k]) l++;
      else lo = 0;
    end
  endtask

  task automatic count_window();
    for (int k = 0; k < NPH; k++) cnt_arr[k] = 0;
    repeat (P) begin
      @(negedge clk);
      for (int k = 0; k < NPH; k++) if (gate_o[k]) cnt_arr[k]++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    int h;
    int l;
    int n6;
    int bad;
    rst_n = 1'b0; spd_i = 2'b00; sync_i = 1'b1; en_i = 1'b1; en_pol_i = 1'b1;
    duty_src_i = 1'b0; filt_duty_i = 4'd5; cpu_duty_i = '0; dith_frac_i = '0;
    ph_mode_i = '0; ph_ofs_i = '0; term_i = 1'b0; ocp_i = 1'b0;
    stop_dis_i = '0; stop_ocp_i = '0; byp_en_i = '0; byp_val_i = '0;
    settle(3);
    check_eq("R12 gates in reset", int'(gate_o), 0);
    rst_n = 1'b1;
    settle(3*P);

    // R1: every duty, every output in pulse-width mode
    for (int d = 0; d < P; d++) begin
      filt_duty_i = DW'(d);
      for (int k = 0; k < NPH; k++) ph_ofs_i[k*DW +: DW] = DW'((d + k) % P);
      settle(3*P);
      count_window();
      for (int k = 0; k < NPH; k++) check_eq("R1 high ticks per cycle", cnt_arr[k], d);
    end

    // R5: duty source select
    filt_duty_i = 4'd3; cpu_duty_i = 4'd11; duty_src_i = 1'b1;
    settle(3*P); count_window();
    check_eq("R5 cpu duty", cnt_arr[0], 11);
    duty_src_i = 1'b0;
    settle(3*P); count_window();
    check_eq("R5 filter duty", cnt_arr[0], 3);

    // R2: phase-shift offsets swept, output 0 stays pulse-width as reference
    filt_duty_i = 4'd5;
    ph_mode_i = 6'b111110;
    for (int o = 0; o < P; o++) begin
      for (int k = 0; k < NPH; k++) ph_ofs_i[k*DW +: DW] = DW'((o + 3*k) % P);
      settle(3*P);
      wait_rise(0);
      for (int j = 0; j < P; j++) begin
        if (j > 0) @(negedge clk);
        for (int k = 0; k < NPH; k++) begin
          int ofs;
          ofs = (k == 0) ? 0 : (o + 3*k) % P;
          check_eq("R2 phase level", int'(gate_o[k]), (((j - ofs + 2*P) % P) < 5) ? 1 : 0);
        end
      end
    end
    ph_mode_i = '0;

    // R3: speed codes scale width and period
    filt_duty_i = 4'd3;
    for (int s = 1; s < 4; s++) begin
      int dv;
      dv = (s == 1) ? 4 : 8;
      spd_i = 2'(s);
      settle(3*P*8);
      wait_rise(0);
      run_len(0, h);
      low_len(0, l);
      check_eq("R3 pulse clocks", h, 3*dv);
      check_eq("R3 period clocks", h + l, P*dv);
    end
    spd_i = 2'b00;
    settle(3*P);

    // R4: mid-cycle duty change waits for the next cycle
    filt_duty_i = 4'd4;
    settle(3*P);
    wait_rise(0);
    filt_duty_i = 4'd9;
    run_len(0, h);
    check_eq("R4 pulse in progress", h, 4);
    low_len(0, l);
    run_len(0, h);
    check_eq("R4 next pulse", h, 9);

    // R6: sync qualification, low run of L ticks then a rising edge
    filt_duty_i = 4'd4;
    settle(3*P);
    for (int t = 0; t < 3; t++) begin
      int L;
      L = (t == 0) ? 2 : ((t == 1) ? 3 : 5);
      wait_rise(0);
      for (int j = 1; j <= P; j++) begin
        @(negedge clk);
        if (L >= 3) begin
          if (j == 3 + L) check_eq("R6 accepted, before restart", int'(gate_o[0]), 0);
          if (j == 4 + L) check_eq("R6 accepted, restarted pulse", int'(gate_o[0]), 1);
        end else begin
          if (j == 4 + L) check_eq("R6 rejected, no restart", int'(gate_o[0]), 0);
          if (j == P - 1) check_eq("R6 rejected, before normal rise", int'(gate_o[0]), 0);
          if (j == P)     check_eq("R6 rejected, normal rise", int'(gate_o[0]), 1);
        end
        if (j == 2) sync_i = 1'b0;
        if (j == 2 + L) sync_i = 1'b1;
      end
      settle(2*P);
    end

    // R7: enable polarity and disable stop levels
    filt_duty_i = 4'd5;
    stop_dis_i = 6'b101001;
    settle(3*P);
    en_i = 1'b0;
    @(negedge clk);
    bad = 0;
    repeat (P) begin
      @(negedge clk);
      if (gate_o != stop_dis_i) bad++;
    end
    check_eq("R7 disabled (active high) samples off pattern", bad, 0);
    en_pol_i = 1'b0;
    settle(2*P);
    count_window();
    for (int k = 0; k < NPH; k++) check_eq("R7 active-low enabled modulates", cnt_arr[k], 5);
    en_i = 1'b1;
    @(negedge clk);
    check_eq("R7 active-low disabled", int'(gate_o), int'(stop_dis_i));
    en_pol_i = 1'b1;

    // R9: bypass on outputs 1 and 2 while the rest modulate
    byp_en_i = 6'b000110;
    byp_val_i = 6'b000100;
    settle(2*P);
    bad = 0;
    for (int k = 0; k < NPH; k++) cnt_arr[k] = 0;
    repeat (P) begin
      @(negedge clk);
      if ((gate_o & byp_en_i) != byp_val_i) bad++;
      for (int k = 0; k < NPH; k++) if (gate_o[k]) cnt_arr[k]++;
    end
    check_eq("R9 forced outputs", bad, 0);
    check_eq("R9 output 0 modulates", cnt_arr[0], 5);
    check_eq("R9 output 3 modulates", cnt_arr[3], 5);
    check_eq("R9 output 5 modulates", cnt_arr[5], 5);
    en_i = 1'b0;
    @(negedge clk);
    check_eq("R9 bypass over disable", int'(gate_o), int'(6'b101101));

    // R8: over-current stop overrides bypass and disable
    stop_ocp_i = 6'b010110;
    ocp_i = 1'b1;
    @(negedge clk);
    check_eq("R8 ocp stop levels", int'(gate_o), int'(6'b010110));
    en_i = 1'b1;
    byp_en_i = '0;
    @(negedge clk);
    check_eq("R8 ocp held", int'(gate_o), int'(6'b010110));
    ocp_i = 1'b0;
    stop_dis_i = '0;
    settle(2*P);
    count_window();
    check_eq("R8 modulation after release", cnt_arr[4], 5);

    // R10: terminate during the pulse blanks the rest of the cycle
    filt_duty_i = 4'd10;
    settle(3*P);
    wait_rise(0);
    for (int j = 1; j <= P; j++) begin
      @(negedge clk);
      check_eq("R10 terminate window", int'(gate_o), (j <= 3 || j == P) ? 63 : 0);
      if (j == 3) term_i = 1'b1;
      if (j == 4) term_i = 1'b0;
    end

    // R11: dither fraction
    filt_duty_i = 4'd5;
    dith_frac_i = '0;
    settle(3*P);
    wait_rise(0);
    bad = 0;
    for (int i = 0; i < 20; i++) begin
      run_len(0, h);
      if (h != 5) bad++;
      low_len(0, l);
    end
    check_eq("R11 zero fraction widths", bad, 0);
    for (int f = 0; f < 2; f++) begin
      dith_frac_i = (f == 0) ? 6'd32 : 6'd63;
      settle(3*P);
      wait_rise(0);
      bad = 0;
      n6 = 0;
      for (int i = 0; i < 120; i++) begin
        run_len(0, h);
        if (h == 6) n6++;
        else if (h != 5) bad++;
        low_len(0, l);
      end
      check_eq("R11 widths only duty or duty+1", bad, 0);
      if (f == 0) check_rng("R11 half fraction share", n6, 36, 84);
      else        check_rng("R11 near-full fraction share", n6, 105, 120);
    end

    report();
    $finish;
  end

endmodule